// File: doc/BRIEF.md
# Paged EEPROM write-buffer and status engine

This block is a clocked, synthesizable device-side model of a 2K x 8 byte-wide nonvolatile memory. The host side works like a static RAM. It has active-low chip enable, output enable and write enable, an 11-bit address, and a data bus split into input, output and per-bit output-enable vectors. An open-drain ready/busy pin is represented by a "pull low" output. All host pins are assumed synchronous to `clk`. Every strobe level is sampled once per clock.

Bytes written by the host are not stored in the array straight away. They are first collected in a one-page staging buffer, where a page is the 32 bytes that share address bits 10..5. A load timer restarts each time a byte is accepted. When the timer runs out with no new byte, the engine runs an internal programming phase of a fixed number of cycles. At the end of that phase it commits only the buffered bytes that were actually loaded. While the buffer is open or programming is running, reads return a status byte instead of array data. That status byte carries a data-polling bit, a toggle bit and a load-timer bit. A sticky flag reports bytes that were dropped because they fell outside the open page.

Top module: `eeprom_page_engine`

## Requirements
- R1: A read is active when `ce_n`=0, `oe_n`=0 and `we_n`=1. One clock after a sampled active read with the engine idle, `dq_oe`=8'hFF and `dq_out` holds the array byte at `addr`. One clock after any cycle without an active read, `dq_oe`=0.
- R2: After reset, every array location reads 8'hFF.
- R3: A write strobe is active while `ce_n`=0, `we_n`=0 and `oe_n`=1, and either enable may be the one that opens or closes it. The address is taken in the first active cycle. The data is taken in the last active cycle.
- R4: The page is `addr[10:5]` of the first byte. Each accepted byte restarts a load timer of LOAD_CYC cycles. When the timer runs out, programming starts. At commit, only the loaded locations change, and a repeated location keeps its latest byte.
- R5: `busy_pull` is 1 from the clock after the first accepted byte's strobe closes, for exactly LOAD_CYC+PROG_CYC cycles when only one byte is loaded. After that, written data reads back.
- R6: A read while `busy_pull`=1 returns a status byte with `dq_oe`=8'hE0, so bits 4..0 are not driven. Bit 7 of the status byte is the inverse of bit 7 of the last loaded byte.
- R7: Status bit 6 is 0 during the load phase. During programming it alternates on each new read, and the first read returns 0.
- R8: Status bit 5 is 0 while the load timer runs and 1 during programming.
- R9: Write strobes during programming are ignored and do not change the array.
- R10: A byte whose `addr[10:5]` differs from the open page is dropped and sets `page_err`. `page_err` stays 1 until reset.
- R11: Write strobes are ignored for INHIBIT_CYC cycles after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Byte address |
| dq_in | input | 8 | Write data from host |
| dq_out | output | 8 | Read data or status byte |
| dq_oe | output | 8 | Per-bit output drive enable |
| busy_pull | output | 1 | 1 = ready/busy pin pulled low |
| page_err | output | 1 | Sticky off-page write flag |

## Verification
The hardest situation to reach is a run of status reads that lands inside the programming window. Each read there must flip bit 6 and raise bit 5, while a stray write in the same window must leave no trace. The bench shrinks the load and programming counts and measures its position from the cycle in which a write strobe closes. This places its reads either inside the load phase or after the timer has run out. The write task also moves the address and data during the strobe, so capture of the first address and the last data is exercised on every byte.

// File: rtl/epe_pkg.sv
// Shared types and constants for the paged EEPROM engine.
package epe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } epe_state_e;

    localparam int          DQ_W      = 8;
    localparam logic [7:0]  STATUS_OE = 8'hE0;
endpackage

// File: rtl/epe_strobe.sv
// Strobe decoder: turns the sampled enable levels into read and write events.
// Assumes host pins are synchronous to clk. The address is latched in the first
// cycle the write strobe is active; data tracks the bus while active, so the
// latched value is the one from the last active cycle.
module epe_strobe #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_done,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rd_act,
    output logic              rd_start
);
    logic wr_act, wr_q, rd_q;

    assign wr_act   = !ce_n && !we_n && oe_n;
    assign rd_act   = !ce_n && !oe_n && we_n;
    assign wr_done  = wr_q && !wr_act;
    assign rd_start = rd_act && !rd_q;

    // Track strobe history and latch address and data of the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            if (wr_act && !wr_q) wr_addr <= addr;
            if (wr_act)          wr_data <= din;
        end
    end
endmodule

// File: rtl/epe_seq.sv
// Sequencer: post-reset write inhibit, load timer and programming timer.
// Assumes LOAD_CYC >= 2, PROG_CYC >= 2, INHIBIT_CYC >= 1.
module epe_seq
    import epe_pkg::*;
#(
    parameter int LOAD_CYC    = 100,
    parameter int PROG_CYC    = 5000,
    parameter int INHIBIT_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_done,
    input  logic       load_ok,
    output logic       accept,
    output epe_state_e state,
    output logic       commit
);
    localparam int LW = $clog2(LOAD_CYC + 1);
    localparam int PW = $clog2(PROG_CYC + 1);
    localparam int IW = $clog2(INHIBIT_CYC + 1);

    logic [LW-1:0] load_cnt;
    logic [PW-1:0] prog_cnt;
    logic [IW-1:0] inh_cnt;

    assign accept = wr_done && (inh_cnt == '0) && (state != ST_PROG);
    assign commit = (state == ST_PROG) && (prog_cnt == PW'(PROG_CYC - 1));

    // Count down the write inhibit window after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)              inh_cnt <= IW'(INHIBIT_CYC);
        else if (inh_cnt != '0)  inh_cnt <= inh_cnt - 1'b1;
    end

    // Step the idle / load / program state machine and its timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            load_cnt <= '0;
            prog_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (load_ok) begin
                    state    <= ST_LOAD;
                    load_cnt <= '0;
                end
                ST_LOAD: begin
                    if (load_ok) load_cnt <= '0;
                    else if (load_cnt == LW'(LOAD_CYC - 1)) begin
                        state    <= ST_PROG;
                        prog_cnt <= '0;
                    end else load_cnt <= load_cnt + 1'b1;
                end
                ST_PROG: begin
                    if (commit) state <= ST_IDLE;
                    else        prog_cnt <= prog_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_inhibit_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_cnt != '0) |-> (state == ST_IDLE));
    assert_prog_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && prog_cnt != PW'(PROG_CYC - 1)) |=> (state == ST_PROG));
    assert_prog_noload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |=> (state != ST_LOAD));
endmodule

// File: rtl/epe_pagebuf.sv
// Page staging buffer: holds up to one page of bytes with a per-byte valid mask.
// The first accepted byte fixes the page; bytes for another page are dropped
// and raise a sticky error.
module epe_pagebuf #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept,
    input  logic                     idle,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [7:0]               wr_data,
    input  logic                     commit,
    output logic                     load_ok,
    output logic [ADDR_W-PAGE_W-1:0] base,
    output logic [(8<<PAGE_W)-1:0]   buf_flat,
    output logic [(1<<PAGE_W)-1:0]   valid,
    output logic [7:0]               last_data,
    output logic                     err
);
    localparam int BW = ADDR_W - PAGE_W;

    logic [BW-1:0]     page;
    logic [PAGE_W-1:0] off;
    logic              match;

    assign page    = wr_addr[ADDR_W-1:PAGE_W];
    assign off     = wr_addr[PAGE_W-1:0];
    assign match   = (page == base);
    assign load_ok = accept && (idle || match);

    // Store accepted bytes, track valid slots and the sticky off-page flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base      <= '0;
            buf_flat  <= '0;
            valid     <= '0;
            last_data <= '0;
            err       <= 1'b0;
        end else begin
            if (commit) valid <= '0;
            if (load_ok) begin
                if (idle) base <= page;
                buf_flat[off*8 +: 8] <= wr_data;
                valid[off]           <= 1'b1;
                last_data            <= wr_data;
            end
            if (accept && !idle && !match) err <= 1'b1;
        end
    end

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    assert_commit_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (valid == '0));
endmodule

// File: rtl/epe_array.sv
// Storage array: all ones after reset; on commit, writes the valid slots of the
// staging buffer into the selected page. Combinational read port.
module epe_array #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] base,
    input  logic [(1<<PAGE_W)-1:0]   valid,
    input  logic [(8<<PAGE_W)-1:0]   buf_flat,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SLOTS = 1 << PAGE_W;

    logic [7:0] mem [DEPTH];

    assign rdata = mem[rd_addr];

    // Erase on reset; copy loaded slots into the page on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < SLOTS; i++)
                if (valid[i]) mem[{base, PAGE_W'(i)}] <= buf_flat[i*8 +: 8];
        end
    end
endmodule

// File: rtl/eeprom_page_engine.sv
// Top: byte-wide EEPROM model with page staging, timed programming and status
// reads. Outputs are registered one clock after the sampled read strobe.
module eeprom_page_engine
    import epe_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int LOAD_CYC    = 100,
    parameter int PROG_CYC    = 5000,
    parameter int INHIBIT_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic [7:0]        dq_oe,
    output logic              busy_pull,
    output logic              page_err
);
    localparam int BW = ADDR_W - PAGE_W;

    logic              wr_done, rd_act, rd_start, accept, load_ok, commit, tog_q;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data, last_data, rdata;
    logic [BW-1:0]     base;
    logic [(8<<PAGE_W)-1:0] buf_flat;
    logic [(1<<PAGE_W)-1:0] valid;
    epe_state_e        state;

    epe_strobe #(.ADDR_W(ADDR_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(dq_in), .wr_done(wr_done), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_act(rd_act), .rd_start(rd_start));

    epe_seq #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC), .INHIBIT_CYC(INHIBIT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .load_ok(load_ok),
        .accept(accept), .state(state), .commit(commit));

    epe_pagebuf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .accept(accept), .idle(state == ST_IDLE),
        .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit), .load_ok(load_ok),
        .base(base), .buf_flat(buf_flat), .valid(valid), .last_data(last_data),
        .err(page_err));

    epe_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit), .base(base), .valid(valid),
        .buf_flat(buf_flat), .rd_addr(addr), .rdata(rdata));

    assign busy_pull = (state != ST_IDLE);

    // Drive the read bus: array data when idle, status byte while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= '0;
            tog_q  <= 1'b0;
        end else begin
            if (state != ST_PROG) tog_q <= 1'b0;
            else if (rd_start)    tog_q <= ~tog_q;
            if (!rd_act) begin
                dq_out <= '0;
                dq_oe  <= '0;
            end else if (state == ST_IDLE) begin
                dq_out <= rdata;
                dq_oe  <= '1;
            end else begin
                dq_oe  <= STATUS_OE;
                dq_out <= {~last_data[7],
                           (state == ST_PROG) ? (rd_start ? tog_q : dq_out[6]) : 1'b0,
                           state == ST_PROG, 5'b0};
            end
        end
    end

    assert_bus_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n) |=> (dq_oe == '0));
    assert_status_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_pull && !ce_n && !oe_n && we_n) |=> (dq_oe == STATUS_OE));
endmodule

// File: tb/sim_eeprom_page_engine.sv
module sim_eeprom_page_engine;
    localparam int CLK_PERIOD = 10;
    localparam int LOAD_CYC   = 16;
    localparam int PROG_CYC   = 64;
    localparam int INH_CYC    = 20;

    logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
    logic [10:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out, dq_oe;
    logic        busy_pull, page_err;
    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] rd_val, rd_oe;

    eeprom_page_engine #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC),
                         .INHIBIT_CYC(INH_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .busy_pull(busy_pull), .page_err(page_err));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write one byte; address and data move during the strobe to test capture.
    task automatic wr(logic [10:0] a, logic [7:0] d, bit ce_ctrl);
        @(negedge clk);
        oe_n = 1; addr = a; dq_in = ~d;
        if (ce_ctrl) begin we_n = 0; ce_n = 0; end else begin ce_n = 0; we_n = 0; end
        @(negedge clk);
        addr = ~a; dq_in = d;
        @(negedge clk);
        if (ce_ctrl) ce_n = 1; else we_n = 1;
        @(negedge clk);
        ce_n = 1; we_n = 1;
    endtask

    task automatic rd(logic [10:0] a);
        @(negedge clk);
        addr = a; we_n = 1; ce_n = 0; oe_n = 0;
        @(negedge clk);
        rd_val = dq_out; rd_oe = dq_oe;
        ce_n = 1; oe_n = 1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy_pull; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset oe", dq_oe, 0);
        chk("R5 reset busy", busy_pull, 0);
        chk("R10 reset err", page_err, 0);
    endtask

    task automatic t_inhibit();
        wr(11'h010, 8'h5A, 0);
        chk("R11 no busy in inhibit", busy_pull, 0);
        rd(11'h010);
        chk("R11 inhibited write lost", rd_val, 8'hFF);
        chk("R1 idle read oe", rd_oe, 8'hFF);
        rd(11'h7FF);
        chk("R2 erased top byte", rd_val, 8'hFF);
        repeat (INH_CYC + 5) @(negedge clk);
    endtask

    task automatic t_page();
        wr(11'h041, 8'h11, 0);
        wr(11'h045, 8'h85, 0);
        wr(11'h05F, 8'h9C, 0);
        chk("R5 busy after load", busy_pull, 1);
        rd(11'h000);
        chk("R6 status oe", rd_oe, 8'hE0);
        chk("R6 poll bit", rd_val[7], 0);
        chk("R7 toggle in load", rd_val[6], 0);
        chk("R8 timer running", rd_val[5], 0);
        repeat (LOAD_CYC + 2) @(negedge clk);
        rd(11'h041);
        chk("R7 first toggle", rd_val[6], 0);
        chk("R8 timer expired", rd_val[5], 1);
        rd(11'h123);
        chk("R7 second toggle", rd_val[6], 1);
        wr(11'h041, 8'h77, 0);
        rd(11'h041);
        chk("R7 third toggle", rd_val[6], 0);
        chk("R6 poll during prog", rd_val[7], 0);
        chk("R9 no error from ignored write", page_err, 0);
        wait_idle();
        rd(11'h041);
        chk("R9 prog-time write ignored", rd_val, 8'h11);
        rd(11'h045);
        chk("R4 second byte", rd_val, 8'h85);
        rd(11'h05F);
        chk("R4 last byte", rd_val, 8'h9C);
        rd(11'h042);
        chk("R4 unloaded slot", rd_val, 8'hFF);
    endtask

    task automatic t_ce_offpage();
        wr(11'h123, 8'h42, 1);
        rd(11'h000);
        chk("R6 poll inverted", rd_val[7], 1);
        wr(11'h200, 8'h99, 1);
        chk("R10 error set", page_err, 1);
        wait_idle();
        rd(11'h123);
        chk("R3 ce-controlled capture", rd_val, 8'h42);
        rd(11'h200);
        chk("R10 off-page dropped", rd_val, 8'hFF);
    endtask

    task automatic t_duration();
        int cnt;
        wr(11'h7FF, 8'h00, 0);
        cnt = busy_pull ? 1 : 0;
        for (int i = 0; i < 1000 && busy_pull; i++) begin
            @(negedge clk);
            if (busy_pull) cnt++;
        end
        chk("R5 busy length", cnt, LOAD_CYC + PROG_CYC);
        rd(11'h7FF);
        chk("R5 data after program", rd_val, 8'h00);
        chk("R10 error sticky", page_err, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_inhibit();
        t_page();
        t_ce_offpage();
        t_duration();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule